// File: doc/BRIEF.md
# Block Address Translation Register Bank

This block holds block-address-translation entries for a processor's memory management unit. There are two banks, one for instruction fetches and one for data accesses. Each bank has `NPAIR` entries. Each entry is an upper word and a lower word:

- The upper word carries the effective base, the block-length field and the two valid bits.
- The lower word carries the physical base and the attribute bits.

Software writes either word through a single write port. A combinational read port returns any stored word. A combinational lookup port translates an effective address against one bank.

An upper-word write masks the base fields by the new block length. When the upper word changes, the block must purge a downstream page cache. It covers two ranges: the one the entry mapped before the write and the one it maps after. The block either issues per-page invalidate requests, one per accepted handshake, or issues a single full-flush request when a range would span too many 4 KiB pages. While the purge runs, the block reports busy and ignores further register writes.

Top module: `bat_bank`

## Requirements
- R1: After reset every stored word reads zero, `busy` and `inv_valid` are low, and every lookup misses.
- R2: A lower-word write (`wr_upper`=0) stores `wr_data` unchanged, touches no other word and starts no invalidation. The entry index is `wr_side*NPAIR + wr_idx`, with side 0 for instructions and 1 for data.
- R3: For an upper-word write of value v, let m = (v << 15) & 0x0FFE0000. The stored upper word is (v & 0x00001FFF) | (v & ~0x0001FFFF & ~m).
- R4: The same write rewrites the entry's lower word L as (L & 0x0000007B) | (L & ~0x0001FFFF & ~m).
- R5: An upper-word write equal to the stored upper word changes nothing and leaves `busy` low.
- R6: A changing upper-word write uses a page count n = (m >> 12) + 32. When n ≤ 1024, it issues n requests starting at the old upper word's base (bits 31:17 kept) and then n requests starting at the new base. The addresses step by 4096 and `inv_all` is low.
- R7: When n > 1024, exactly one request is issued instead, with `inv_all`=1 and `inv_addr`=0.
- R8: A pending request holds `inv_valid`, `inv_addr` and `inv_all` steady until `inv_ready` is high. One request is accepted per cycle in which both are high.
- R9: `busy` is high from the cycle after a changing upper-word write until the cycle after the last request is accepted. Register writes issued while busy are ignored.
- R10: An entry of the bank chosen by `lk_side` is valid when bit 0 or bit 1 of its upper word is set. It matches when (ea & 0xFFFE0000 & ~m) equals (upper & 0xFFFE0000), where m is the entry's own mask. The lowest matching index wins.
- R11: On a hit, `lk_pa` = (lower & 0xFFFE0000 & ~m) | (ea & (m | 0x1FFFF)). On a miss, `lk_hit` and `lk_pa` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_side | input | 1 | Bank of the write: 0 instruction, 1 data |
| wr_idx | input | IW | Entry index within the bank |
| wr_upper | input | 1 | 1 writes the upper word, 0 the lower word |
| wr_data | input | 32 | Write value |
| rd_side | input | 1 | Bank of the read |
| rd_idx | input | IW | Entry index of the read |
| rd_upper | input | 1 | 1 reads the upper word, 0 the lower word |
| rd_data | output | 32 | Selected stored word |
| lk_side | input | 1 | Bank used by the lookup |
| lk_ea | input | 32 | Effective address to translate |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_pa | output | 32 | Translated address |
| busy | output | 1 | Invalidation sequence in progress |
| inv_valid | output | 1 | Invalidate request pending |
| inv_all | output | 1 | Request is a full flush |
| inv_addr | output | 32 | Page address of a per-page request |
| inv_ready | input | 1 | Downstream accepts the request |

## Verification
The embedded assertions check four things on every cycle:

- A stalled request stays steady.
- Consecutive per-page requests step by one page.
- A full flush is a single request that ends the busy period.
- Busy freezes the register file, lower-word writes land verbatim, and equal-value upper writes leave the block idle.

Only the bench's scenarios can show the rest: the masked upper and lower values, the full order of old-range then new-range page addresses, the 1024/1056-page boundary between per-page and full flush, and the lookup's match, priority and address composition. The bench compares these against reference functions, under random write values and random `inv_ready` stalls.

// File: rtl/bat_bank.sv
module bat_bank #(
  parameter int NPAIR      = 4,
  parameter int PAGE_LIMIT = 1024,
  parameter int IW         = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_side,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_upper,
  input  logic [31:0]   wr_data,
  input  logic          rd_side,
  input  logic [IW-1:0] rd_idx,
  input  logic          rd_upper,
  output logic [31:0]   rd_data,
  input  logic          lk_side,
  input  logic [31:0]   lk_ea,
  output logic          lk_hit,
  output logic [31:0]   lk_pa,
  output logic          busy,
  output logic          inv_valid,
  output logic          inv_all,
  output logic [31:0]   inv_addr,
  input  logic          inv_ready
);
  localparam logic [31:0] BL_FIELD = 32'h0FFE_0000;
  localparam logic [31:0] BASE_M   = 32'hFFFE_0000;
  localparam logic [31:0] UP_KEEP  = 32'h0000_1FFF;
  localparam logic [31:0] LO_KEEP  = 32'h0000_007B;
  localparam logic [31:0] OFS_M    = 32'h0001_FFFF;
  localparam logic [31:0] PG_STEP  = 32'h0000_1000;
  localparam int          NE       = 2 * NPAIR;

  typedef enum logic [1:0] {S_IDLE, S_OLD, S_NEW, S_FULL} st_t;

  logic [NE-1:0][31:0] up_q, lo_q;
  st_t                 st;
  logic [31:0]         cur, nbase_q;
  logic [16:0]         cnt, npg_q;

  logic [IW:0]  wsel;
  logic [31:0]  wmask, old_up, old_lo, new_up, new_lo;
  logic [16:0]  npg;
  logic         do_wr, up_chg, big, fire;

  assign wsel   = {wr_side, wr_idx};
  assign old_up = up_q[wsel];
  assign old_lo = lo_q[wsel];
  assign wmask  = (wr_data << 15) & BL_FIELD;
  assign new_up = (wr_data & UP_KEEP) | (wr_data & BASE_M & ~wmask);
  assign new_lo = (old_lo & LO_KEEP) | (old_lo & BASE_M & ~wmask);
  assign npg    = 17'((wmask >> 12) + 32'd32);
  assign big    = npg > 17'(PAGE_LIMIT);
  assign do_wr  = wr_en && !busy;
  assign up_chg = do_wr && wr_upper && (wr_data != old_up);

  assign busy      = st != S_IDLE;
  assign inv_valid = busy;
  assign inv_all   = st == S_FULL;
  assign inv_addr  = inv_all ? 32'h0 : cur;
  assign fire      = inv_valid && inv_ready;

  assign rd_data = rd_upper ? up_q[{rd_side, rd_idx}] : lo_q[{rd_side, rd_idx}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q    <= '0;
      lo_q    <= '0;
      st      <= S_IDLE;
      cur     <= '0;
      nbase_q <= '0;
      cnt     <= '0;
      npg_q   <= '0;
    end else begin
      if (do_wr && !wr_upper) lo_q[wsel] <= wr_data;
      if (up_chg) begin
        up_q[wsel] <= new_up;
        lo_q[wsel] <= new_lo;
        nbase_q    <= new_up & BASE_M;
        npg_q      <= npg;
        cnt        <= npg;
        cur        <= old_up & BASE_M;
        st         <= big ? S_FULL : S_OLD;
      end else if (fire) begin
        if (st == S_FULL) st <= S_IDLE;
        else if (cnt == 17'd1) begin
          if (st == S_OLD) begin
            st  <= S_NEW;
            cur <= nbase_q;
            cnt <= npg_q;
          end else st <= S_IDLE;
        end else begin
          cur <= cur + PG_STEP;
          cnt <= cnt - 17'd1;
        end
      end
    end
  end

  always_comb begin
    logic [IW:0]  e;
    logic [31:0]  m;
    lk_hit = 1'b0;
    lk_pa  = '0;
    for (int i = NPAIR - 1; i >= 0; i--) begin
      e = {lk_side, IW'(i)};
      m = (up_q[e] << 15) & BL_FIELD;
      if ((up_q[e][1:0] != 2'b00) && ((lk_ea & BASE_M & ~m) == (up_q[e] & BASE_M))) begin
        lk_hit = 1'b1;
        lk_pa  = (lo_q[e] & BASE_M & ~m) | (lk_ea & (m | OFS_M));
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_addr) && $stable(inv_all));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_ready && !inv_all && cnt != 17'd1 |=> inv_addr == $past(inv_addr) + PG_STEP);

  p_full_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_ready && inv_all |=> !busy);

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(up_q) && $stable(lo_q));

  p_lower_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !busy && !wr_upper |=> lo_q[$past(wsel)] == $past(wr_data) && !busy);

  p_same_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !busy && wr_upper && wr_data == up_q[wsel] |=> !busy && $stable(up_q));
endmodule

// File: tb/bat_bank_test.sv
module bat_bank_test;
  localparam logic [31:0] BASE = 32'hFFFE_0000;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_side = 0, wr_upper = 0;
  logic [1:0] wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic rd_side = 0, rd_upper = 0;
  logic [1:0] rd_idx = 0;
  logic [31:0] rd_data;
  logic lk_side = 0;
  logic [31:0] lk_ea = 0;
  logic lk_hit;
  logic [31:0] lk_pa;
  logic busy, inv_valid, inv_all, inv_ready = 0;
  logic [31:0] inv_addr;

  int n_chk = 0, n_err = 0;
  logic [31:0] mu [8];
  logic [31:0] ml [8];

  always #10 clk = ~clk;

  bat_bank uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side), .wr_idx(wr_idx),
    .wr_upper(wr_upper), .wr_data(wr_data), .rd_side(rd_side), .rd_idx(rd_idx),
    .rd_upper(rd_upper), .rd_data(rd_data), .lk_side(lk_side), .lk_ea(lk_ea),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .busy(busy), .inv_valid(inv_valid),
    .inv_all(inv_all), .inv_addr(inv_addr), .inv_ready(inv_ready));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] f_mask(logic [31:0] v);
    return (v << 15) & 32'h0FFE_0000;
  endfunction

  function automatic logic [32:0] f_lookup(bit side, logic [31:0] ea);
    for (int i = 0; i < 4; i++) begin
      int e = side * 4 + i;
      logic [31:0] m = f_mask(mu[e]);
      if (mu[e][1:0] != 0 && ((ea & BASE & ~m) == (mu[e] & BASE)))
        return {1'b1, (ml[e] & BASE & ~m) | (ea & (m | 32'h1FFFF))};
    end
    return 33'h0;
  endfunction

  task automatic rd(bit side, int idx, bit up, output logic [31:0] v);
    rd_side = side; rd_idx = 2'(idx); rd_upper = up;
    #1 v = rd_data;
  endtask

  task automatic do_write(bit side, int idx, bit up, logic [31:0] v);
    @(negedge clk);
    wr_en = 1; wr_side = side; wr_idx = 2'(idx); wr_upper = up; wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic check_lookup(bit side, logic [31:0] ea);
    logic [32:0] x = f_lookup(side, ea);
    lk_side = side; lk_ea = ea;
    #1;
    chk("R10 hit", {31'h0, lk_hit}, {31'h0, x[32]});
    chk("R11 pa", lk_pa, x[31:0]);
  endtask

  task automatic drain(bit full, logic [31:0] ob, logic [31:0] nb, int np);
    int total = full ? 1 : 2 * np;
    int k = 0;
    while (k < total) begin
      inv_ready = ($urandom % 4) != 0;
      #1;
      if (inv_valid && inv_ready) begin
        if (full) begin
          chk("R7 inv_all", {31'h0, inv_all}, 32'h1);
          chk("R7 addr", inv_addr, 32'h0);
        end else begin
          logic [31:0] ea = (k < np) ? ob + 32'(k) * 32'h1000 : nb + 32'(k - np) * 32'h1000;
          if (inv_all !== 1'b0 || inv_addr !== ea) chk("R6 page seq", inv_addr, ea);
        end
        k++;
      end else if (!inv_valid) begin
        chk("R8 early end", {31'h0, inv_valid}, 32'h1);
        k = total;
      end
      @(negedge clk);
    end
    inv_ready = 0;
    if (!full) begin n_chk++; end
    chk("R9 busy after", {31'h0, busy}, 32'h0);
  endtask

  task automatic wr_up(bit side, int idx, logic [31:0] v, bit poke);
    int e = side * 4 + idx;
    logic [31:0] m = f_mask(v), ob = mu[e] & BASE, r;
    int np = int'(m >> 12) + 32;
    bit chg = v != mu[e];
    do_write(side, idx, 1, v);
    if (!chg) begin
      chk("R5 busy", {31'h0, busy}, 32'h0);
      rd(side, idx, 1, r); chk("R5 upper", r, mu[e]);
      return;
    end
    mu[e] = (v & 32'h1FFF) | (v & BASE & ~m);
    ml[e] = (ml[e] & 32'h7B) | (ml[e] & BASE & ~m);
    chk("R9 busy", {31'h0, busy}, 32'h1);
    rd(side, idx, 1, r); chk("R3 upper", r, mu[e]);
    rd(side, idx, 0, r); chk("R4 lower", r, ml[e]);
    if (poke) begin
      int e2 = side * 4 + (idx ^ 1);
      do_write(side, idx ^ 1, 0, $urandom);
      do_write(side, idx ^ 1, 1, $urandom);
      rd(side, idx ^ 1, 0, r); chk("R9 ignored lo", r, ml[e2]);
      rd(side, idx ^ 1, 1, r); chk("R9 ignored up", r, mu[e2]);
    end
    drain(np > 1024, ob, mu[e] & BASE, np);
  endtask

  task automatic wr_lo(bit side, int idx, logic [31:0] v);
    logic [31:0] r;
    do_write(side, idx, 0, v);
    ml[side * 4 + idx] = v;
    rd(side, idx, 0, r); chk("R2 lower", r, v);
    chk("R2 busy", {31'h0, busy}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin mu[i] = 0; ml[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rd(i[2], i % 4, 1, r); chk("R1 upper", r, 0);
      rd(i[2], i % 4, 0, r); chk("R1 lower", r, 0);
    end
    chk("R1 busy", {31'h0, busy}, 0);
    chk("R1 valid", {31'h0, inv_valid}, 0);
    check_lookup(0, 32'h0000_0000);
    check_lookup(1, 32'h1234_5678);

    wr_lo(0, 0, 32'hFFFF_FFFF);
    wr_up(0, 0, 32'h8000_0003, 0);
    check_lookup(0, 32'h8001_2345);
    check_lookup(0, 32'h8002_0000);
    wr_up(0, 0, 32'h8000_0003, 0);
    wr_lo(1, 2, 32'h4000_00FF);
    wr_up(1, 2, 32'h4000_007E, 0);
    check_lookup(1, 32'h403E_1234);
    check_lookup(1, 32'h4040_0000);
    wr_up(1, 3, 32'h4000_0002, 0);
    check_lookup(1, 32'h4001_0000);
    wr_up(0, 1, 32'h0000_0082, 0);
    wr_up(0, 1, 32'h0000_1FFF, 0);
    check_lookup(0, 32'h0ABC_DEF0);
    wr_up(0, 2, 32'h1234_0001, 1);

    for (int it = 0; it < 30; it++) begin
      bit side = $urandom % 2;
      int idx = $urandom % 4;
      if ($urandom % 3 == 0) wr_lo(side, idx, $urandom);
      else begin
        logic [31:0] v = ($urandom & ~32'h1FFC) | (32'($urandom % 8) << 2);
        if ($urandom % 8 == 0) v = v | 32'h1FFC;
        wr_up(side, idx, v, 0);
      end
      for (int j = 0; j < 4; j++) begin
        int e = $urandom % 8;
        logic [31:0] ea = (j == 3) ? $urandom : (mu[e] & BASE) | ($urandom & (f_mask(mu[e]) | 32'h1FFFF));
        check_lookup(e[2], ea);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule